// File: doc/BRIEF.md
# Page Write Load Sequencer

This block is the write side of a byte-wide parallel nonvolatile memory model that runs on one synchronous clock. It watches the sampled chip-enable, write-enable and output-enable pins. Each write strobe adds one byte to an on-chip page buffer. A burst takes from 1 to 64 bytes. All bytes of a burst go to the page named by the first byte. Later bytes supply only the byte offset.

The burst stays open only while each new byte starts within a short deadline after the previous one. Once the bus has been quiet for a longer window, the block raises `busy` and runs a timed program cycle. At the end of that cycle it copies every loaded byte into the behavioural array. A combinational read port shows the array byte at the current address.

An active-low reset acts as a write guard. While it is low, no byte is accepted and any loaded bytes are dropped. A program cycle that is running is cut off before anything reaches the array. All times are parameters counted in clock ticks.

Top module: `page_load_seq`

## Requirements
- R1: The address splits into a page number (bits ADDR_W-1 down to 6) and a byte offset (bits 5 to 0). One burst can fill all 64 offsets of a page.
- R2: The page number is taken from the first byte of a burst. Later bytes use only their offset bits, whatever page bits they carry.
- R3: The write strobe is active when ce_n is 0, we_n is 0 and oe_n is 1. A byte's address is sampled on the clock where the strobe is first seen active. Its data is sampled on the clock where the strobe is first seen inactive.
- R4: A further byte joins the burst only if its strobe is first seen active at most LOAD_WIN clocks after the previous accepted byte's strobe. A later strobe is ignored completely.
- R5: `busy` goes high exactly QUIET clocks after the clock on which the last accepted byte's data was sampled.
- R6: `busy` stays high for exactly PROG_CYC clocks. The loaded bytes are readable on `rd_data` from the clock on which `busy` falls.
- R7: If an offset is loaded more than once in a burst, the last value is kept. Offsets not loaded keep their previous array contents.
- R8: Strobes seen while `busy` is high are ignored and do not start a new burst.
- R9: A strobe with oe_n at 0 is not recognised as a write.
- R10: While rst_n is 0, `busy` is 0 and no byte is accepted. Loaded bytes are discarded. A program cycle cut off by rst_n leaves the array unchanged.
- R11: `rd_data` shows the array byte at `addr` without clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and write guard |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; blocks writes when low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| busy | output | 1 | High during the program cycle |
| rd_data | output | DATA_W | Array byte at `addr` |

## Verification
The strobe-on clock fixes a byte's address, and the strobe-off clock two edges later fixes its data. `busy` is due high QUIET edges after that strobe-off clock and low PROG_CYC edges later. The bench keeps its own edge counter and records the strobe-on and strobe-off edge numbers of every byte it drives. It samples `busy` at the falling clock edge one edge before and exactly at each due edge. Array contents are read through `rd_data` only after `busy` has fallen, and they are compared with a shadow array that the bench updates from its own acceptance rule.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_e;

  // Counter value k-1 on the k-th edge after a clear: inside the window if k <= limit
  function automatic logic fits_window(input int unsigned elapsed, input int unsigned limit);
    return elapsed < limit;
  endfunction

  // True on the limit-th edge after a clear
  function automatic logic reached(input int unsigned elapsed, input int unsigned limit);
    return (elapsed + 1) >= limit;
  endfunction

endpackage

// File: rtl/pwl_strobe.sv
module pwl_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic on_ev,
  output logic off_ev
);
  logic act;
  logic act_q;

  assign act = !ce_n && !we_n && oe_n;

  // Reset to "active" so a strobe held through reset is never taken as new
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b1;
    else        act_q <= act;
  end

  assign on_ev  = act && !act_q;
  assign off_ev = !act && act_q;
endmodule

// File: rtl/pwl_timer.sv
module pwl_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwl_page_buf.sv
module pwl_page_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int OW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [OW-1:0]             wofs,
  input  logic [DW-1:0]             wdata,
  input  logic                      flush,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][DW-1:0]  dat_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic          v_q;
    logic [DW-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (wr && wofs == OW'(s)) begin
        v_q <= 1'b1;
        d_q <= wdata;
      end else if (flush) begin
        v_q <= 1'b0;
      end
    end
    assign vld_o[s] = v_q;
    assign dat_o[s] = d_q;
  end
endmodule

// File: rtl/page_load_seq.sv
module page_load_seq
  import pwl_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int LOAD_WIN   = 30,
  parameter int QUIET      = 100,
  parameter int PROG_CYC   = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data
);
  localparam int OFS_W     = $clog2(PAGE_BYTES);
  localparam int PG_W      = ADDR_W - OFS_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int MAX_A     = (QUIET > LOAD_WIN) ? QUIET : LOAD_WIN;
  localparam int CNT_MAX   = (PROG_CYC > MAX_A) ? PROG_CYC : MAX_A;
  localparam int CW        = $clog2(CNT_MAX + 1);

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  phase_e            ph_q;
  logic [PG_W-1:0]   page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              in_byte_q;

  // Named internal events
  logic s_on, s_off;
  logic byte_take, byte_land, quiet_done, prog_done, in_win;
  logic [CW-1:0] gap_cnt, idle_cnt;
  logic [PAGE_BYTES-1:0]             buf_vld;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_dat;

  pwl_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .on_ev(s_on), .off_ev(s_off)
  );

  // Time since the last accepted strobe-on
  pwl_timer #(.CW(CW)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(byte_take), .cnt(gap_cnt)
  );

  // Time since the last data sample, reused for the program cycle
  pwl_timer #(.CW(CW)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(byte_land || quiet_done), .cnt(idle_cnt)
  );

  assign in_win     = fits_window(32'(gap_cnt), LOAD_WIN);
  assign byte_take  = s_on && ((ph_q == PH_IDLE) || (ph_q == PH_LOAD && in_win));
  assign byte_land  = s_off && in_byte_q;
  assign quiet_done = (ph_q == PH_LOAD) && !in_byte_q && !byte_take
                      && reached(32'(idle_cnt), QUIET);
  assign prog_done  = (ph_q == PH_PROG) && reached(32'(idle_cnt), PROG_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      page_q    <= '0;
      ofs_q     <= '0;
      in_byte_q <= 1'b0;
    end else begin
      if (byte_take) begin
        ofs_q     <= offset_of(addr);
        in_byte_q <= 1'b1;
        if (ph_q == PH_IDLE) begin
          page_q <= page_of(addr);
          ph_q   <= PH_LOAD;
        end
      end else if (byte_land) begin
        in_byte_q <= 1'b0;
      end
      if (quiet_done) ph_q <= PH_PROG;
      if (prog_done)  ph_q <= PH_IDLE;
    end
  end

  pwl_page_buf #(.DW(DATA_W), .DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr(byte_land), .wofs(ofs_q), .wdata(din),
    .flush(prog_done),
    .vld_o(buf_vld), .dat_o(buf_dat)
  );

  // Behavioural array, kept across reset
  logic [DATA_W-1:0] mem [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (prog_done) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (buf_vld[i]) mem[{page_q, OFS_W'(i)}] <= buf_dat[i];
      end
    end
  end

  assign busy    = (ph_q == PH_PROG);
  assign rd_data = mem[addr];
endmodule

// File: rtl/page_load_seq_chk.sv
module page_load_seq_chk #(
  parameter int PROG_CYC = 400
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic oe_n,
  input logic byte_take,
  input logic byte_land,
  input logic quiet_done,
  input logic prog_done
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == PROG_CYC));

  assert_commit_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy);

  assert_entry_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(quiet_done));

  assert_no_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_take && !byte_land);

  assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> oe_n);
endmodule

bind page_load_seq page_load_seq_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .oe_n(oe_n),
  .byte_take(byte_take), .byte_land(byte_land),
  .quiet_done(quiet_done), .prog_done(prog_done)
);

// File: tb/sim_page_load_seq.sv
module sim_page_load_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int LW = 30;
  localparam int QT = 100;
  localparam int PC = 400;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic busy;
  logic [7:0] rd_data;

  page_load_seq #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(64),
                  .LOAD_WIN(LW), .QUIET(QT), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;

  // Shadow array and pending burst
  logic [7:0] sh [1 << AW];
  bit         kn [1 << AW];
  logic [7:0] pend_d [64];
  bit         pend_v [64];
  bit open = 0;
  int pend_page = 0, last_take = 0, last_land = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One byte: strobe low for two edges; address a, then a2 while low;
  // data d0, then d1 before release. track=1 lets the model decide acceptance.
  task automatic put_byte(input int a, input int a2, input int d0, input int d1,
                          input bit oe_lo, input bit track);
    int f;
    bit acc;
    acc = 0;
    @(negedge clk); addr = AW'(a); din = 8'(d0); oe_n = !oe_lo; ce_n = 0; we_n = 0;
    @(negedge clk); f = cyc; addr = AW'(a2); din = 8'(d1);
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk); oe_n = 1;
    if (track) begin
      if (!open) begin
        open = 1; pend_page = a >> 6; last_take = f; acc = 1;
        for (int i = 0; i < 64; i++) pend_v[i] = 0;
      end else if (f - last_take <= LW) begin
        last_take = f; acc = 1;
      end
      if (acc) begin
        pend_v[a & 63] = 1; pend_d[a & 63] = 8'(d1); last_land = cyc;
      end
    end
  endtask

  task automatic see_start();
    int t;
    t = last_land + QT;
    while (cyc < t - 1) @(negedge clk);
    chk("R5 busy low one edge before quiet expiry", int'(busy), 0);
    @(negedge clk);
    chk("R5 busy high at quiet expiry", int'(busy), 1);
  endtask

  task automatic see_end();
    int t;
    t = last_land + QT + PC;
    while (cyc < t - 1) @(negedge clk);
    chk("R6 busy still high on last program edge", int'(busy), 1);
    @(negedge clk);
    chk("R6 busy low after program length", int'(busy), 0);
    for (int i = 0; i < 64; i++)
      if (pend_v[i]) begin
        sh[pend_page*64 + i] = pend_d[i];
        kn[pend_page*64 + i] = 1;
      end
    open = 0;
  endtask

  task automatic read_at(input int a, output int v);
    @(negedge clk); addr = AW'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic check_page(input int p, input string req);
    int v;
    for (int o = 0; o < 64; o++)
      if (kn[p*64 + o]) begin
        read_at(p*64 + o, v);
        chk(req, v, int'(sh[p*64 + o]));
      end
  endtask

  task automatic watch_quiet(input int n, input string req);
    int ones;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) ones++;
    end
    chk(req, ones, 0);
  endtask

  initial begin
    int v, p, n, o, d, old9, old21;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < (1 << AW); i++) kn[i] = 0;
    repeat (3) @(negedge clk);
    chk("R10 busy low in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 busy low after reset", int'(busy), 0);

    // R1: fill pages 0..5 with full 64-byte bursts
    for (int pg = 0; pg < 6; pg++) begin
      for (int i = 0; i < 64; i++) begin
        d = $urandom_range(0, 255);
        put_byte(pg*64 + i, pg*64 + i, d, d, 0, 1);
      end
      see_start(); see_end();
      check_page(pg, "R1 full page and R11 read");
    end

    // R3: address at strobe-on, data at strobe-off
    old21 = int'(sh[0*64 + 21]);
    put_byte(20, 21, 8'h11, 8'h77, 0, 1);
    see_start(); see_end();
    read_at(20, v); chk("R3 data taken at strobe-off", v, 8'h77);
    read_at(21, v); chk("R3 later address ignored", v, old21);

    // R2: page locked to first byte
    old9 = int'(sh[2*64 + 9]);
    put_byte(1*64 + 5, 1*64 + 5, 8'h3c, 8'h3c, 0, 1);
    put_byte(2*64 + 9, 2*64 + 9, 8'hc3, 8'hc3, 0, 1);
    see_start(); see_end();
    read_at(1*64 + 9, v); chk("R2 byte lands in first page", v, 8'hc3);
    read_at(2*64 + 9, v); chk("R2 other page untouched", v, old9);

    // R4: boundary accepted (fall-to-fall 30), then late (31) ignored
    put_byte(3*64 + 10, 3*64 + 10, 8'ha1, 8'ha1, 0, 1);
    repeat (26) @(negedge clk);
    put_byte(3*64 + 12, 3*64 + 12, 8'ha2, 8'ha2, 0, 1);
    old9 = int'(sh[3*64 + 11]);
    repeat (27) @(negedge clk);
    put_byte(3*64 + 11, 3*64 + 11, 8'ha3, 8'ha3, 0, 1);
    see_start(); see_end();
    read_at(3*64 + 12, v); chk("R4 byte at window edge accepted", v, 8'ha2);
    read_at(3*64 + 11, v); chk("R4 late byte ignored", v, old9);

    // R7: repeated offset keeps last, others keep old
    put_byte(4*64 + 7, 4*64 + 7, 8'h01, 8'h01, 0, 1);
    put_byte(4*64 + 7, 4*64 + 7, 8'h02, 8'h02, 0, 1);
    put_byte(4*64 + 7, 4*64 + 7, 8'h5a, 8'h5a, 0, 1);
    see_start(); see_end();
    read_at(4*64 + 7, v); chk("R7 last write wins", v, 8'h5a);
    check_page(4, "R7 untouched offsets keep old");

    // R9: oe_n low blocks the strobe
    put_byte(0*64 + 30, 0*64 + 30, 8'hee, 8'hee, 1, 0);
    watch_quiet(QT + PC + 10, "R9 no program after oe-low strobe");
    check_page(0, "R9 array unchanged");

    // R8: strobe during busy ignored
    put_byte(2*64 + 40, 2*64 + 40, 8'h99, 8'h99, 0, 1);
    see_start();
    repeat (20) @(negedge clk);
    put_byte(5*64 + 3, 5*64 + 3, 8'h66, 8'h66, 0, 0);
    see_end();
    watch_quiet(QT + PC + 10, "R8 no burst from strobe during busy");
    check_page(5, "R8 array unchanged");
    check_page(2, "R8 committed page");

    // R10: reset during load discards bytes; strobes under reset ignored
    put_byte(0*64 + 1, 0*64 + 1, 8'hd1, 8'hd1, 0, 1);
    @(negedge clk); rst_n = 0;
    put_byte(0*64 + 2, 0*64 + 2, 8'hd2, 8'hd2, 0, 0);
    @(negedge clk); rst_n = 1;
    open = 0;
    watch_quiet(QT + PC + 10, "R10 no program after reset in load");
    check_page(0, "R10 array unchanged after reset in load");

    // R10: reset during program aborts without writing
    put_byte(1*64 + 50, 1*64 + 50, 8'hb7, 8'hb7, 0, 1);
    see_start();
    repeat (50) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R10 busy cleared by reset", int'(busy), 0);
    rst_n = 1;
    open = 0;
    watch_quiet(QT + PC + 10, "R10 aborted cycle does not resume");
    check_page(1, "R10 aborted page unchanged");

    // Random bursts
    for (int b = 0; b < 12; b++) begin
      p = $urandom_range(0, 5);
      n = $urandom_range(1, 8);
      for (int j = 0; j < n; j++) begin
        o = $urandom_range(0, 15);
        d = $urandom_range(0, 255);
        put_byte(p*64 + o, p*64 + o, d, d, 0, 1);
        if (j < n - 1) repeat ($urandom_range(0, 26)) @(negedge clk);
      end
      see_start(); see_end();
      check_page(p, "R7 random burst page contents");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule